// File: doc/BRIEF.md
# Pulsed Interrupt Event Aggregator

This block collects wake events and fault events from a power-management companion device and reports them to a host microcontroller over one active-low interrupt line. Each qualifying event latches into a sticky status bit and raises an interrupt request. The request becomes a low pulse of fixed length on the line, and the line then stays high for at least a minimum gap before another pulse can start. Requests that arrive during a pulse or a gap are merged and held until the gap ends.

A class select input decides whether only wake events interrupt (class 0, the default) or fault events interrupt as well (class 1). A bus timeout event counts as a wake source, but its own enable input alone decides whether it interrupts, whatever the class. Critical faults (the kind that force a restart or fail-safe) are latched for the host but never interrupt. Live wake levels can be read but are never latched and never interrupt. Entering stop mode while any wake status is still latched raises an extra interrupt. Events first collect in a hidden pending layer. They move into the host-visible status when a pulse starts, that is, on the falling edge of the line. The host reads one group at a time and clears it with a strobe.

Top module: `irq_pulse_agg`

## Requirements
- R1: After a cause while the line is idle, `irq_no` falls on the second rising clock edge. It then stays low for exactly PULSE_CYC cycles and returns high by itself.
- R2: Between two pulses, `irq_no` stays high for at least GAP_CYC cycles. A request held during a pulse or a gap starts its pulse right after exactly GAP_CYC high cycles. Any number of causes during one pulse produce only one further pulse.
- R3: With `global_cls_i`=0, a wake strobe on bit i raises an interrupt only if `wake_en_i[i]`=1. A strobe on a disabled wake bit is neither latched nor raises an interrupt.
- R4: A `tmo_evt_i` strobe always latches at bit N_WAKE of group 0. It raises an interrupt if and only if `tmo_irq_en_i`=1, whatever the value of `global_cls_i`.
- R5: A `fault_evt_i` strobe always latches in group 1. It raises an interrupt only when `global_cls_i`=1.
- R6: A `crit_evt_i` strobe latches in group 2 and never raises an interrupt, in either class.
- R7: Group 3 reads the live `wake_lvl_i` value. It is not latched, never interrupts, and ignores clear.
- R8: A `stop_entry_i` strobe raises an interrupt if any group-0 bit is latched (visible or pending). Otherwise it does nothing.
- R9: Group encoding on `rd_grp_i`: 0 = wake (bits N_WAKE-1..0 wake, bit N_WAKE timeout), 1 = fault, 2 = critical, 3 = live level. `rd_data_o` is combinational, zero-extended, and all groups read 0 after reset. Pending events become visible only on the edge where `irq_no` falls, and they stay visible until cleared. A `rd_clr_i` strobe zeroes the visible bits of the selected group. An event strobed in the same cycle as a clear is kept and becomes visible at the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_evt_i | input | N_WAKE | Wake event strobes |
| wake_en_i | input | N_WAKE | Per-source wake enables |
| wake_lvl_i | input | N_WAKE | Live wake levels (group 3) |
| tmo_evt_i | input | 1 | Bus timeout event strobe |
| tmo_irq_en_i | input | 1 | Timeout interrupt enable, overrides class |
| fault_evt_i | input | N_FAULT | Interrupt-capable fault strobes |
| crit_evt_i | input | N_CRIT | Critical fault strobes, never interrupt |
| global_cls_i | input | 1 | 0 = wake-only class, 1 = global class |
| stop_entry_i | input | 1 | Stop-mode entry strobe |
| rd_grp_i | input | 2 | Status group select |
| rd_clr_i | input | 1 | Clear strobe for the selected group |
| rd_data_o | output | DATA_W | Selected group contents |
| irq_no | output | 1 | Active-low interrupt pulse output |

## Verification
The bench measures every pulse width and every high gap. A shaper with an off-by-one counter would produce pulses one cycle long or short. One that went through idle between back-to-back pulses would stretch the gap to GAP_CYC+1, and one that queued each cause separately would emit extra pulses. Class tests catch designs that let faults interrupt in class 0, ignore the timeout enable, or interrupt on critical faults. A bench read before the pulse catches a design that exposes status before the falling edge. A clear landing in the same cycle as a new event catches one that drops the event.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    GRP_WAKE  = 2'd0,
    GRP_FAULT = 2'd1,
    GRP_CRIT  = 2'd2,
    GRP_LEVEL = 2'd3
  } grp_e;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_LOW  = 2'd1,
    SH_GAP  = 2'd2
  } shp_e;
endpackage

// File: rtl/irq_src_filter.sv
module irq_src_filter #(
  parameter int N_WAKE  = 4,
  parameter int N_FAULT = 4
) (
  input  logic [N_WAKE-1:0]  wake_evt_i,
  input  logic [N_WAKE-1:0]  wake_en_i,
  input  logic               tmo_evt_i,
  input  logic               tmo_irq_en_i,
  input  logic [N_FAULT-1:0] fault_evt_i,
  input  logic               global_cls_i,
  input  logic               stop_entry_i,
  input  logic               wake_any_i,
  output logic [N_WAKE:0]    wake_set_o,
  output logic               trig_o
);
  logic [N_WAKE-1:0] wake_ok;
  logic              wake_hit, tmo_hit, fault_hit, stop_hit;

  for (genvar i = 0; i < N_WAKE; i++) begin : g_wake
    assign wake_ok[i] = wake_evt_i[i] & wake_en_i[i];
  end

  // timeout always latched; its own enable overrides class select
  assign wake_set_o = {tmo_evt_i, wake_ok};
  assign wake_hit   = |wake_ok;
  assign tmo_hit    = tmo_evt_i & tmo_irq_en_i;
  assign fault_hit  = global_cls_i & (|fault_evt_i);
  assign stop_hit   = stop_entry_i & wake_any_i;
  assign trig_o     = wake_hit | tmo_hit | fault_hit | stop_hit;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         cap_i,
  input  logic         clr_i,
  output logic [W-1:0] vis_o,
  output logic         any_o
);
  logic [W-1:0] pend_q, vis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      vis_q  <= '0;
    end else begin
      pend_q <= (cap_i ? '0 : pend_q) | evt_i;
      vis_q  <= (clr_i ? '0 : vis_q) | (cap_i ? pend_q : '0);
    end
  end

  assign vis_o = vis_q;
  assign any_o = |(vis_q | pend_q);

  // R9
  vis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !clr_i) |=> $stable(vis_q));
  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/irq_pulse_shaper.sv
module irq_pulse_shaper
  import irq_agg_pkg::*;
#(
  parameter int PULSE_CYC = 8,
  parameter int GAP_CYC   = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic start_o,
  output logic irq_no
);
  localparam int MAXC = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] P_END = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] G_END = CW'(GAP_CYC - 1);

  shp_e          st_q;
  logic [CW-1:0] cnt_q;
  logic          irq_q;

  assign start_o = req_i && ((st_q == SH_IDLE) || (st_q == SH_GAP && cnt_q == G_END));
  assign irq_no  = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SH_IDLE;
      cnt_q <= '0;
      irq_q <= 1'b1;
    end else begin
      case (st_q)
        SH_IDLE: if (req_i) begin
          st_q  <= SH_LOW;
          cnt_q <= '0;
          irq_q <= 1'b0;
        end
        SH_LOW: if (cnt_q == P_END) begin
          st_q  <= SH_GAP;
          cnt_q <= '0;
          irq_q <= 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
        SH_GAP: if (cnt_q == G_END) begin
          // held request fires straight out of the gap
          st_q  <= req_i ? SH_LOW : SH_IDLE;
          irq_q <= !req_i;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: begin
          st_q  <= SH_IDLE;
          cnt_q <= '0;
          irq_q <= 1'b1;
        end
      endcase
    end
  end

  // run-length monitors for the output line
  logic [CW-1:0] lo_run_q, hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run_q <= '0;
      hi_run_q <= CW'(GAP_CYC);
    end else begin
      lo_run_q <= irq_q ? '0 : ((lo_run_q == CW'(MAXC)) ? lo_run_q : lo_run_q + 1'b1);
      hi_run_q <= !irq_q ? '0 : ((hi_run_q == CW'(MAXC)) ? hi_run_q : hi_run_q + 1'b1);
    end
  end

  // R1
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> (lo_run_q == CW'(PULSE_CYC)));
  // R2
  gap_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_q) |-> (hi_run_q >= CW'(GAP_CYC)));
endmodule

// File: rtl/irq_pulse_agg.sv
module irq_pulse_agg
  import irq_agg_pkg::*;
#(
  parameter int N_WAKE    = 4,
  parameter int N_FAULT   = 4,
  parameter int N_CRIT    = 5,
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 8,
  parameter int GAP_CYC   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_WAKE-1:0]  wake_evt_i,
  input  logic [N_WAKE-1:0]  wake_en_i,
  input  logic [N_WAKE-1:0]  wake_lvl_i,
  input  logic               tmo_evt_i,
  input  logic               tmo_irq_en_i,
  input  logic [N_FAULT-1:0] fault_evt_i,
  input  logic [N_CRIT-1:0]  crit_evt_i,
  input  logic               global_cls_i,
  input  logic               stop_entry_i,
  input  logic [1:0]         rd_grp_i,
  input  logic               rd_clr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_no
);
  localparam int WW = N_WAKE + 1;

  logic [WW-1:0]      wake_set, wake_vis;
  logic [N_FAULT-1:0] fault_vis;
  logic [N_CRIT-1:0]  crit_vis;
  logic               wake_any, fault_any, crit_any;
  logic               trig, start, req_q;
  logic [3:0]         clr_dec;
  grp_e               grp;

  assign grp = grp_e'(rd_grp_i);
  always_comb begin
    clr_dec = '0;
    clr_dec[rd_grp_i] = rd_clr_i;
  end

  irq_src_filter #(.N_WAKE(N_WAKE), .N_FAULT(N_FAULT)) u_filt (
    .wake_evt_i   (wake_evt_i),
    .wake_en_i    (wake_en_i),
    .tmo_evt_i    (tmo_evt_i),
    .tmo_irq_en_i (tmo_irq_en_i),
    .fault_evt_i  (fault_evt_i),
    .global_cls_i (global_cls_i),
    .stop_entry_i (stop_entry_i),
    .wake_any_i   (wake_any),
    .wake_set_o   (wake_set),
    .trig_o       (trig)
  );

  irq_status_bank #(.W(WW)) u_wake (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(wake_set), .cap_i(start),
    .clr_i(clr_dec[GRP_WAKE]), .vis_o(wake_vis), .any_o(wake_any)
  );
  irq_status_bank #(.W(N_FAULT)) u_fault (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(fault_evt_i), .cap_i(start),
    .clr_i(clr_dec[GRP_FAULT]), .vis_o(fault_vis), .any_o(fault_any)
  );
  irq_status_bank #(.W(N_CRIT)) u_crit (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(crit_evt_i), .cap_i(start),
    .clr_i(clr_dec[GRP_CRIT]), .vis_o(crit_vis), .any_o(crit_any)
  );

  // one merged request; a new cause in the start cycle keeps it armed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= (req_q & ~start) | trig;
  end

  irq_pulse_shaper #(.PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_shp (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_q), .start_o(start), .irq_no(irq_no)
  );

  always_comb begin
    case (grp)
      GRP_WAKE:  rd_data_o = DATA_W'(wake_vis);
      GRP_FAULT: rd_data_o = DATA_W'(fault_vis);
      GRP_CRIT:  rd_data_o = DATA_W'(crit_vis);
      default:   rd_data_o = DATA_W'(wake_lvl_i);
    endcase
  end

  logic unused_any;
  assign unused_any = fault_any ^ crit_any;

  // R3 R5 R6: the request only rises after a qualifying cause at the ports
  req_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past((|(wake_evt_i & wake_en_i)) || (tmo_evt_i && tmo_irq_en_i) ||
                           (global_cls_i && (|fault_evt_i)) || stop_entry_i));
  // R8
  stop_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_entry_i && wake_any) |=> req_q);
endmodule

// File: tb/irq_pulse_agg_test.sv
module irq_pulse_agg_test;
  localparam int NW = 4, NF = 4, NC = 5, DW = 8, P = 8, G = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NW-1:0] wake_evt = '0, wake_en = '0, wake_lvl = '0;
  logic tmo_evt = 0, tmo_en = 0, gcls = 0, stop_e = 0, clr = 0;
  logic [NF-1:0] fault_evt = '0;
  logic [NC-1:0] crit_evt = '0;
  logic [1:0] grp = '0;
  logic [DW-1:0] rdata;
  logic irq_n;

  always #2 clk = ~clk;

  irq_pulse_agg #(.N_WAKE(NW), .N_FAULT(NF), .N_CRIT(NC), .DATA_W(DW),
                  .PULSE_CYC(P), .GAP_CYC(G)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wake_evt_i(wake_evt), .wake_en_i(wake_en),
    .wake_lvl_i(wake_lvl), .tmo_evt_i(tmo_evt), .tmo_irq_en_i(tmo_en),
    .fault_evt_i(fault_evt), .crit_evt_i(crit_evt), .global_cls_i(gcls),
    .stop_entry_i(stop_e), .rd_grp_i(grp), .rd_clr_i(clr), .rd_data_o(rdata),
    .irq_no(irq_n));

  int total = 0, bad = 0, pulses = 0, last_gap = 0;
  int exp_q[$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: each finished pulse pops one expected item
  int lo = 0, hi = 1000;
  logic prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev && !irq_n) begin
        last_gap = hi;
        chk(hi >= G, "R2 gap", hi, G);
      end
      if (!prev && irq_n) begin
        pulses++;
        if (exp_q.size() == 0) chk(0, "R1 unexpected pulse", pulses, 0);
        else void'(exp_q.pop_front());
        chk(lo == P, "R1 width", lo, P);
      end
      if (irq_n) begin hi++; lo = 0; end else begin lo++; hi = 0; end
      prev = irq_n;
    end
  end

  task automatic expect_pulse(input int n); for (int i = 0; i < n; i++) exp_q.push_back(i); endtask
  task automatic settle(); repeat (P + G + 8) @(negedge clk); endtask
  task automatic wake(input logic [NW-1:0] v);
    @(negedge clk); wake_evt = v; @(negedge clk); wake_evt = '0;
  endtask
  task automatic rd(input int g, output int v);
    @(negedge clk); grp = 2'(g); #1 v = int'(rdata);
  endtask
  task automatic clear(input int g);
    @(negedge clk); grp = 2'(g); clr = 1; @(negedge clk); clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(irq_n == 1, "R1 reset line", irq_n, 1);
    for (int g = 0; g < 3; g++) begin rd(g, v); chk(v == 0, "R9 reset group", v, 0); end

    // R1 latency and R3 enabled wake
    wake_en = 4'b0011;
    @(negedge clk); wake_evt = 4'b0001; expect_pulse(1);
    @(negedge clk); wake_evt = '0;
    chk(irq_n == 1, "R1 before 2nd edge", irq_n, 1);
    @(negedge clk);
    chk(irq_n == 0, "R1 low on 2nd edge", irq_n, 0);
    settle();
    rd(0, v); chk(v == 8'h01, "R3 wake visible", v, 1);
    clear(0); rd(0, v); chk(v == 0, "R9 clear", v, 0);

    // R3 disabled wake
    p0 = pulses; wake(4'b0100); settle();
    chk(pulses == p0, "R3 disabled no irq", pulses - p0, 0);
    expect_pulse(1); wake(4'b0010); settle();
    rd(0, v); chk(v == 8'h02, "R3 disabled not latched", v, 2);
    clear(0);

    // R5 class 0 fault latched silently, R9 not visible before pulse
    p0 = pulses;
    @(negedge clk); fault_evt = 4'b0001; @(negedge clk); fault_evt = '0;
    settle();
    chk(pulses == p0, "R5 class0 fault no irq", pulses - p0, 0);
    rd(1, v); chk(v == 0, "R9 hidden before pulse", v, 0);
    gcls = 1; expect_pulse(1);
    @(negedge clk); fault_evt = 4'b1000; @(negedge clk); fault_evt = '0;
    settle();
    rd(1, v); chk(v == 8'h09, "R5 class1 fault", v, 9);
    clear(1);

    // R6 critical never interrupts
    p0 = pulses;
    @(negedge clk); crit_evt = 5'b10101; @(negedge clk); crit_evt = '0;
    settle();
    chk(pulses == p0, "R6 crit no irq", pulses - p0, 0);
    expect_pulse(1); wake(4'b0001); settle();
    rd(2, v); chk(v == 8'h15, "R6 crit latched", v, 21);
    clear(2); clear(0);

    // R4 timeout override
    gcls = 0; tmo_en = 1; expect_pulse(1);
    @(negedge clk); tmo_evt = 1; @(negedge clk); tmo_evt = 0;
    settle();
    rd(0, v); chk(v == 8'h10, "R4 tmo class0", v, 16);
    clear(0);
    gcls = 1; tmo_en = 0; p0 = pulses;
    @(negedge clk); tmo_evt = 1; @(negedge clk); tmo_evt = 0;
    settle();
    chk(pulses == p0, "R4 tmo masked", pulses - p0, 0);
    expect_pulse(1); wake(4'b0001); settle();
    rd(0, v); chk(v == 8'h11, "R4 tmo latched", v, 17);
    clear(0); gcls = 0;

    // R2 burst: causes during one pulse merge into one held pulse
    p0 = pulses; expect_pulse(2);
    wake(4'b0001);
    repeat (2) @(negedge clk); wake(4'b0010);
    @(negedge clk); wake(4'b0001);
    settle(); settle();
    chk(pulses - p0 == 2, "R2 merged count", pulses - p0, 2);
    chk(last_gap == G, "R2 held gap exact", last_gap, G);
    clear(0);

    // R8 stop entry
    expect_pulse(1); wake(4'b0001); settle();
    expect_pulse(1);
    @(negedge clk); stop_e = 1; @(negedge clk); stop_e = 0;
    settle();
    chk(exp_q.size() == 0, "R8 stop with status", exp_q.size(), 0);
    clear(0); p0 = pulses;
    @(negedge clk); stop_e = 1; @(negedge clk); stop_e = 0;
    settle();
    chk(pulses == p0, "R8 stop clean", pulses - p0, 0);

    // R9 set wins over clear
    expect_pulse(1); wake(4'b0010); settle();
    expect_pulse(1);
    @(negedge clk); grp = 0; clr = 1; wake_evt = 4'b0001;
    @(negedge clk); clr = 0; wake_evt = '0;
    settle();
    rd(0, v); chk(v == 8'h01, "R9 set wins", v, 1);
    clear(0);

    // R7 live level group
    p0 = pulses;
    wake_lvl = 4'b1010; rd(3, v); chk(v == 8'h0A, "R7 level", v, 10);
    wake_lvl = 4'b0101; rd(3, v); chk(v == 8'h05, "R7 level live", v, 5);
    clear(3); rd(3, v); chk(v == 8'h05, "R7 clear ignored", v, 5);
    settle();
    chk(pulses == p0, "R7 no irq", pulses - p0, 0);

    chk(exp_q.size() == 0, "R1 missing pulses", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule